// File: doc/BRIEF.md
# Serial EEPROM Page Writer with Ready Polling

This block copies a buffer from a local byte memory into a serial EEPROM on an I2C bus. It splits the buffer into pages of `PAGE_BYTES` bytes, 32 by default. Each page is one bus transaction. The transaction sends the device select byte for a write, then the two bytes of the memory address with the high byte first, then the page data, then a stop. After a page's stop the EEPROM runs an internal programming cycle. During that cycle it answers its select byte with a not-acknowledge. This block handles that with acknowledge polling instead of a fixed wait. When the select byte of the next page is refused, the block sends start plus select again. It keeps doing so until the device answers, or until `POLL_LIMIT` refusals within one page end the run with a timeout.

The block does not touch the bus wires itself. It drives a byte-level I2C master through a command stream and receives one response per command. A command is one of three operations: start followed by a byte, a byte alone, or a stop. The command stream uses valid/ready rules. `cmd_valid` rises with an operation and a byte, and it holds both unchanged until a cycle in which `cmd_ready` is high. That cycle is the handshake. The master may hold `cmd_ready` low for as long as it likes. The response side has no back-pressure. The master pulses `rsp_valid` for one cycle when the accepted command has finished, and for byte operations it reports `rsp_ack`. Only one command is outstanding at a time.

Software starts a run with a one-cycle `go` pulse. The pulse carries the device address, the page-aligned EEPROM start address and the byte count. The run ends in one of three result flags: done, bus error or timeout. Each flag stays set until the next accepted `go`.

Top module: `eep_page_writer`

## Requirements
- R1: During and after reset, `busy`, `done`, `bus_err`, `timeout` and `cmd_valid` are low.
- R2: A `go` in idle with `xfer_len` equal to 0 sets `done` on the next clock edge. It sets neither `busy` nor `cmd_valid`.
- R3: A page transaction is issued in this order:
  - op 1 (start then byte) with byte `{dev_sel,0}`;
  - op 2 (byte alone) with the high byte of `ee_base + offset`;
  - op 2 with the low byte;
  - op 2 with each buffer byte, read at `mem_raddr = offset + i` in rising `i`;
  - op 3 (stop).
- R4: Pages hold `PAGE_BYTES` bytes, except that the last page holds only the remainder of `xfer_len`. After a page's stop the offset advances by `PAGE_BYTES`. When the new offset reaches `xfer_len`, the block sets `done` and returns to idle.
- R5: Once a write has been issued since reset, a refused select is not an error. The block re-issues op 1 with the select byte, with no stop in between, and after an accepted select it continues with the address bytes.
- R6: After `POLL_LIMIT` (1024) refused selects within one page, the block issues op 3, sets `timeout` and returns to idle. The per-page refusal count never reaches `POLL_LIMIT` while the block is busy.
- R7: If no select has been accepted and stopped since reset, a refused select is treated as an error. The block issues op 3, sets `bus_err` and returns to idle. A write counts as issued once a stop follows an accepted select.
- R8: A refused address or data byte is also an error. The block sends op 3 next, sends no further byte, and sets `bus_err`. Both `bus_err` and `timeout` rise only right after a stop command.
- R9: Command stream rules:
  - `cmd_valid` with `cmd_op` and `cmd_byte` holds stable until `cmd_ready`;
  - after a handshake `cmd_valid` stays low until `rsp_valid` arrives;
  - `cmd_valid` is low whenever `busy` is low.
- R10: A `go` while `busy` is high is ignored, and the run in progress continues unchanged. An accepted `go` clears the result flags. At most one flag is high, and none is high while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | One-cycle request to start a run |
| dev_sel | input | 7 | 7-bit device address, captured at go |
| ee_base | input | 16 | Page-aligned EEPROM start address, captured at go |
| xfer_len | input | 16 | Byte count, captured at go |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished normally |
| bus_err | output | 1 | Run aborted on a refused byte |
| timeout | output | 1 | Run aborted by the polling limit |
| mem_raddr | output | 16 | Buffer read address |
| mem_rdata | input | 8 | Buffer read data, combinational from mem_raddr |
| cmd_valid | output | 1 | Command offered to the byte master |
| cmd_ready | input | 1 | Byte master accepts the command |
| cmd_op | output | 2 | 1 start+byte, 2 byte, 3 stop |
| cmd_byte | output | 8 | Byte to send with op 1 or 2 |
| rsp_valid | input | 1 | One-cycle completion of the accepted command |
| rsp_ack | input | 1 | Receiver acknowledged the byte |

## Verification
The checks assume three things about the byte master. It answers each accepted command with exactly one `rsp_valid` pulse. That pulse never comes before the cycle after the handshake. It never pulses `rsp_valid` while no command is open. The checks also assume that `mem_rdata` depends only on `mem_raddr`, so the offered byte stays stable while `cmd_valid` waits for `cmd_ready`. The bench's master model keeps to these rules. It answers one to three cycles after each handshake, varies the length of its `cmd_ready` stalls, and serves buffer bytes from a pure function of the address. All refusals come from the model's own busy counter and error position.

// File: rtl/eep_pkg.sv
package eep_pkg;

  localparam int EA_W = 16;

  typedef enum logic [1:0] {
    OP_NONE     = 2'd0,
    OP_START_WR = 2'd1,
    OP_WRITE    = 2'd2,
    OP_STOP     = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    PH_SEL,
    PH_AHI,
    PH_ALO,
    PH_DAT,
    PH_STOP
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } state_e;

  typedef enum logic [1:0] {
    END_OK,
    END_BUSERR,
    END_TIMEOUT
  } end_e;

endpackage

// File: rtl/eep_page_ctr.sv
module eep_page_ctr #(
  parameter int PAGE_BYTES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [15:0] len_in,
  input  logic [15:0] base_in,
  input  logic        step_byte,
  input  logic        step_page,
  output logic [15:0] buf_idx,
  output logic [15:0] ee_addr,
  output logic        page_last_byte,
  output logic        run_last_page
);
  localparam int          IDX_W  = $clog2(PAGE_BYTES);
  localparam logic [16:0] PAGE_W = 17'(PAGE_BYTES);

  logic [15:0]      off_q, len_q, base_q;
  logic [IDX_W-1:0] idx_q;
  logic [16:0]      cur_w, nxt_off_w;

  always_comb begin
    cur_w          = {1'b0, off_q} + 17'(idx_q);
    nxt_off_w      = {1'b0, off_q} + PAGE_W;
    buf_idx        = cur_w[15:0];
    ee_addr        = base_q + off_q;
    page_last_byte = (idx_q == IDX_W'(PAGE_BYTES - 1)) ||
                     ((cur_w + 17'd1) == {1'b0, len_q});
    run_last_page  = (nxt_off_w >= {1'b0, len_q});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q  <= '0;
      idx_q  <= '0;
      len_q  <= '0;
      base_q <= '0;
    end else if (load) begin
      off_q  <= '0;
      idx_q  <= '0;
      len_q  <= len_in;
      base_q <= base_in;
    end else if (step_page) begin
      off_q  <= nxt_off_w[15:0];
      idx_q  <= '0;
    end else if (step_byte) begin
      idx_q  <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/eep_poll_ctr.sv
module eep_poll_ctr #(
  parameter int LIMIT = 1024,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             last_try
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt      = cnt_q;
  assign last_try = (cnt_q == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clr)               cnt_q <= '0;
    else if (inc && !last_try)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/eep_cmd_fmt.sv
module eep_cmd_fmt
  import eep_pkg::*;
(
  input  phase_e      phase,
  input  logic [6:0]  dev,
  input  logic [15:0] ee_addr,
  input  logic [7:0]  data,
  output op_e         op,
  output logic [7:0]  byte_o
);
  always_comb begin
    op     = OP_NONE;
    byte_o = 8'h00;
    case (phase)
      PH_SEL:  begin op = OP_START_WR; byte_o = {dev, 1'b0};    end
      PH_AHI:  begin op = OP_WRITE;    byte_o = ee_addr[15:8];  end
      PH_ALO:  begin op = OP_WRITE;    byte_o = ee_addr[7:0];   end
      PH_DAT:  begin op = OP_WRITE;    byte_o = data;           end
      PH_STOP: begin op = OP_STOP;     byte_o = 8'h00;          end
      default: begin op = OP_NONE;     byte_o = 8'h00;          end
    endcase
  end
endmodule

// File: rtl/eep_page_writer.sv
module eep_page_writer
  import eep_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int POLL_LIMIT = 1024,
  parameter int POLL_W     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [6:0]  dev_sel,
  input  logic [15:0] ee_base,
  input  logic [15:0] xfer_len,
  output logic        busy,
  output logic        done,
  output logic        bus_err,
  output logic        timeout,
  output logic [15:0] mem_raddr,
  input  logic [7:0]  mem_rdata,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [1:0]  cmd_op,
  output logic [7:0]  cmd_byte,
  input  logic        rsp_valid,
  input  logic        rsp_ack
);
  state_e state_q;
  phase_e phase_q;
  end_e   end_q;
  logic   primed_q, sel_ok_q, done_q, err_q, to_q;
  logic [6:0] dev_q;

  logic accept_go, rsp_in;
  logic step_byte, step_page, poll_inc, poll_clr;
  logic page_last_byte, run_last_page, poll_last;
  logic [15:0] ee_addr;
  logic [POLL_W-1:0] poll_cnt;
  op_e  op_w;

  assign accept_go = go && (state_q == ST_IDLE);
  assign rsp_in    = (state_q == ST_WAIT) && rsp_valid;
  assign step_byte = rsp_in && (phase_q == PH_DAT) && rsp_ack && !page_last_byte;
  assign step_page = rsp_in && (phase_q == PH_STOP) && (end_q == END_OK) && !run_last_page;
  assign poll_inc  = rsp_in && (phase_q == PH_SEL) && !rsp_ack;
  assign poll_clr  = accept_go || step_page;

  eep_page_ctr #(.PAGE_BYTES(PAGE_BYTES)) u_page (
    .clk            (clk),
    .rst_n          (rst_n),
    .load           (accept_go),
    .len_in         (xfer_len),
    .base_in        (ee_base),
    .step_byte      (step_byte),
    .step_page      (step_page),
    .buf_idx        (mem_raddr),
    .ee_addr        (ee_addr),
    .page_last_byte (page_last_byte),
    .run_last_page  (run_last_page)
  );

  eep_poll_ctr #(.LIMIT(POLL_LIMIT), .CNT_W(POLL_W)) u_poll (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (poll_clr),
    .inc      (poll_inc),
    .cnt      (poll_cnt),
    .last_try (poll_last)
  );

  eep_cmd_fmt u_fmt (
    .phase   (phase_q),
    .dev     (dev_q),
    .ee_addr (ee_addr),
    .data    (mem_rdata),
    .op      (op_w),
    .byte_o  (cmd_byte)
  );

  assign cmd_op    = op_w;
  assign cmd_valid = (state_q == ST_ISSUE);
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign bus_err   = err_q;
  assign timeout   = to_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      phase_q  <= PH_SEL;
      end_q    <= END_OK;
      primed_q <= 1'b0;
      sel_ok_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      to_q     <= 1'b0;
      dev_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (go) begin
            done_q   <= (xfer_len == 16'd0);
            err_q    <= 1'b0;
            to_q     <= 1'b0;
            dev_q    <= dev_sel;
            phase_q  <= PH_SEL;
            end_q    <= END_OK;
            sel_ok_q <= 1'b0;
            if (xfer_len != 16'd0) state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (cmd_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            state_q <= ST_ISSUE;
            case (phase_q)
              PH_SEL: begin
                if (rsp_ack) begin
                  phase_q  <= PH_AHI;
                  sel_ok_q <= 1'b1;
                end else if (!primed_q) begin
                  end_q   <= END_BUSERR;
                  phase_q <= PH_STOP;
                end else if (poll_last) begin
                  end_q   <= END_TIMEOUT;
                  phase_q <= PH_STOP;
                end
              end
              PH_AHI: begin
                if (rsp_ack) phase_q <= PH_ALO;
                else begin end_q <= END_BUSERR; phase_q <= PH_STOP; end
              end
              PH_ALO: begin
                if (rsp_ack) phase_q <= PH_DAT;
                else begin end_q <= END_BUSERR; phase_q <= PH_STOP; end
              end
              PH_DAT: begin
                if (!rsp_ack) begin
                  end_q   <= END_BUSERR;
                  phase_q <= PH_STOP;
                end else if (page_last_byte) begin
                  phase_q <= PH_STOP;
                end
              end
              PH_STOP: begin
                if (sel_ok_q) primed_q <= 1'b1;
                sel_ok_q <= 1'b0;
                phase_q  <= PH_SEL;
                if (end_q == END_OK) begin
                  if (run_last_page) begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                  end
                end else begin
                  err_q   <= (end_q == END_BUSERR);
                  to_q    <= (end_q == END_TIMEOUT);
                  state_q <= ST_IDLE;
                end
              end
              default: phase_q <= PH_SEL;
            endcase
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eep_seq_chk.sv
module eep_seq_chk #(
  parameter int POLL_LIMIT = 1024,
  parameter int CNT_W      = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             bus_err,
  input logic             timeout,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_op,
  input logic [7:0]       cmd_byte,
  input logic             rsp_valid,
  input logic [CNT_W-1:0] poll_cnt
);
  logic open_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      open_q <= 1'b0;
    else if (cmd_valid && cmd_ready) open_q <= 1'b1;
    else if (rsp_valid)              open_q <= 1'b0;
  end

  assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)));

  assert_drop_after_hs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_valid);

  assert_no_cmd_while_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> !cmd_valid);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid);

  assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, bus_err, timeout}));

  assert_busy_no_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(done || bus_err || timeout));

  assert_poll_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (poll_cnt < CNT_W'(POLL_LIMIT)));

  assert_abort_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_err) || $rose(timeout)) |-> $past(cmd_op == 2'd3));
endmodule

bind eep_page_writer eep_seq_chk #(.POLL_LIMIT(POLL_LIMIT), .CNT_W(POLL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .bus_err   (bus_err),
  .timeout   (timeout),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_byte  (cmd_byte),
  .rsp_valid (rsp_valid),
  .poll_cnt  (poll_cnt)
);

// File: tb/tb_eep_page_writer.sv
module tb_eep_page_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [6:0]  dev_sel = '0;
  logic [15:0] ee_base = '0;
  logic [15:0] xfer_len = '0;
  logic        busy, done, bus_err, timeout;
  logic [15:0] mem_raddr;
  logic [7:0]  mem_rdata;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [1:0]  cmd_op;
  logic [7:0]  cmd_byte;
  logic        rsp_valid = 1'b0;
  logic        rsp_ack = 1'b0;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] dat(input logic [15:0] i);
    return 8'((i * 37 + 11) & 16'hff);
  endfunction

  assign mem_rdata = dat(mem_raddr);

  eep_page_writer dut (
    .clk(clk), .rst_n(rst_n), .go(go), .dev_sel(dev_sel), .ee_base(ee_base),
    .xfer_len(xfer_len), .busy(busy), .done(done), .bus_err(bus_err),
    .timeout(timeout), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack)
  );

  // scoreboard
  logic [9:0] exp_q [$];
  string      req_q [$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic [7:0] b, input string req);
    exp_q.push_back({op, b});
    req_q.push_back(req);
  endtask

  task automatic push_page(input logic [6:0] dev, input logic [15:0] ee,
                           input int off, input int n, input int polls, input string req);
    for (int k = 0; k < polls; k++) push(2'd1, {dev, 1'b0}, "R5");
    push(2'd1, {dev, 1'b0}, req);
    push(2'd2, ee[15:8], "R3");
    push(2'd2, ee[7:0], "R3");
    for (int k = 0; k < n; k++) push(2'd2, dat(16'(off + k)), req);
    push(2'd3, 8'h00, req);
  endtask

  // byte-master and device model
  int ee_busy = 0;
  int busy_reload = 0;
  int nack_at = -1;
  int byte_no = 0;
  bit sel_acked = 0;
  bit pend = 0;
  bit pend_ack = 0;
  int pend_dly = 0;
  int stall = 0;
  int hs_cnt = 0;

  always @(negedge clk) begin
    rsp_valid = 1'b0;
    if (!rst_n) begin
      cmd_ready = 1'b0;
      pend = 0;
    end else begin
      if (pend) begin
        if (pend_dly == 0) begin
          rsp_valid = 1'b1;
          rsp_ack   = pend_ack;
          pend      = 0;
        end else pend_dly--;
      end
      if (!pend && !rsp_valid) begin
        if (stall > 0) begin stall--; cmd_ready = 1'b0; end
        else cmd_ready = 1'b1;
      end else cmd_ready = 1'b0;
      if (cmd_ready && cmd_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R9", "unexpected command", int'({cmd_op, cmd_byte}), 0);
        end else begin
          automatic logic [9:0] e = exp_q.pop_front();
          automatic string r = req_q.pop_front();
          check({cmd_op, cmd_byte} == e, r, "command", int'({cmd_op, cmd_byte}), int'(e));
        end
        case (cmd_op)
          2'd1: begin
            byte_no = 0;
            if (ee_busy > 0) begin pend_ack = 0; ee_busy--; sel_acked = 0; end
            else begin pend_ack = 1; sel_acked = 1; end
          end
          2'd2: begin
            pend_ack = (byte_no != nack_at);
            byte_no++;
          end
          default: begin
            pend_ack = 1;
            if (sel_acked) ee_busy = busy_reload;
            sel_acked = 0;
          end
        endcase
        pend     = 1;
        pend_dly = hs_cnt % 3;
        stall    = hs_cnt % 2;
        hs_cnt++;
      end
    end
  end

  task automatic run(input logic [6:0] dev, input logic [15:0] base,
                     input logic [15:0] len, input int poke_at);
    @(negedge clk);
    go = 1'b1; dev_sel = dev; ee_base = base; xfer_len = len;
    @(negedge clk);
    go = 1'b0;
    for (int c = 0; busy; c++) begin
      if (poke_at > 0 && c == poke_at) begin
        go = 1'b1; dev_sel = 7'h7f; ee_base = 16'hff00; xfer_len = 16'd5;
      end else go = 1'b0;
      @(negedge clk);
    end
    go = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic end_of_run(input string req, input bit d, input bit e, input bit t);
    check(exp_q.size() == 0, req, "commands left over", exp_q.size(), 0);
    exp_q.delete(); req_q.delete();
    check(busy == 1'b0, req, "busy", busy, 0);
    check({done, bus_err, timeout} == {d, e, t}, req, "flags {done,err,to}",
          {done, bus_err, timeout}, {d, e, t});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({busy, done, bus_err, timeout, cmd_valid} == 5'b0, "R1", "in reset",
          {busy, done, bus_err, timeout, cmd_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({busy, done, bus_err, timeout, cmd_valid} == 5'b0, "R1", "after reset",
          {busy, done, bus_err, timeout, cmd_valid}, 0);

    // R2: zero length
    go = 1'b1; xfer_len = 16'd0; dev_sel = 7'h50;
    @(negedge clk);
    go = 1'b0;
    check({done, busy, cmd_valid} == 3'b100, "R2", "len0 {done,busy,valid}",
          {done, busy, cmd_valid}, 3'b100);
    repeat (3) @(negedge clk);
    end_of_run("R2", 1, 0, 0);

    // R7: select refused before any write
    ee_busy = 1; busy_reload = 0;
    push(2'd1, {7'h50, 1'b0}, "R7");
    push(2'd3, 8'h00, "R7");
    run(7'h50, 16'h0000, 16'd10, 0);
    end_of_run("R7", 0, 1, 0);

    // R3 R4: three pages, polling between them (R5)
    ee_busy = 0; busy_reload = 3;
    push_page(7'h50, 16'h0000, 0, 32, 0, "R3");
    push_page(7'h50, 16'h0020, 32, 32, 3, "R4");
    push_page(7'h50, 16'h0040, 64, 6, 3, "R4");
    run(7'h50, 16'h0000, 16'd70, 0);
    end_of_run("R4", 1, 0, 0);

    // R10: go while busy ignored; nonzero base, polls on first page (R5)
    push_page(7'h51, 16'h1200, 0, 32, 3, "R10");
    push_page(7'h51, 16'h1220, 32, 8, 3, "R5");
    run(7'h51, 16'h1200, 16'd40, 15);
    end_of_run("R10", 1, 0, 0);

    // R6: endless refusal
    ee_busy = 5000;
    for (int k = 0; k < 1024; k++) push(2'd1, {7'h52, 1'b0}, "R6");
    push(2'd3, 8'h00, "R6");
    run(7'h52, 16'h0000, 16'd8, 0);
    end_of_run("R6", 0, 0, 1);

    // R8: data byte refused (fourth data byte)
    ee_busy = 0; busy_reload = 0; nack_at = 5;
    push(2'd1, {7'h53, 1'b0}, "R8");
    push(2'd2, 8'h00, "R8");
    push(2'd2, 8'h00, "R8");
    for (int k = 0; k < 4; k++) push(2'd2, dat(16'(k)), "R8");
    push(2'd3, 8'h00, "R8");
    run(7'h53, 16'h0000, 16'd20, 0);
    end_of_run("R8", 0, 1, 0);

    // R4: last page of a single byte
    nack_at = -1; ee_busy = 0; busy_reload = 2;
    push_page(7'h50, 16'h0100, 0, 32, 0, "R4");
    push_page(7'h50, 16'h0120, 32, 1, 2, "R4");
    run(7'h50, 16'h0100, 16'd33, 0);
    end_of_run("R4", 1, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule